// File: doc/BRIEF.md
# SRAM Sleep Mode Controller

This block sits in front of a synchronous SRAM array and handles the low-power sleep state. A sleep request arrives with no timing relation to the clock. It passes through a two-stage synchroniser, and that delay sets the latency: the block reports sleep two rising edges after the request goes high, and reports wake two rising edges after the request goes low. The array keeps its contents throughout. No power switching happens here.

Access strobes (chip selects and address strobes) pass through this block on their way to the array. Strobes are stopped once the synchronised request has reached its first stage. They stay stopped while the block is asleep and during a recovery interval after wake. The recovery interval is a parameterised number of cycles and is timed by a down-counter that is loaded when sleep ends. A strobe that shows up in any of these windows is an access that the array may not complete. The block blocks it and sets a sticky fault flag.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `asleep_o`, `recovering_o` and `fault_o` are cleared. After reset, with the request low, strobes pass unchanged.
- R2: A request that rises between edges makes `asleep_o` go high after the second rising edge that follows.
- R3: A request that falls between edges makes `asleep_o` go low after the second rising edge that follows.
- R4: `recovering_o` goes high at the same edge at which `asleep_o` goes low. It then stays high for exactly `RECOV_CYC` clock cycles.
- R5: All bits of `cs_o` and `stb_o` are 0 in the blocked window. The window begins after the first rising edge that samples the request high. It lasts while `asleep_o` or `recovering_o` is high.
- R6: Outside the blocked window, `cs_o` equals `cs_i` and `stb_o` equals `stb_i` in the same cycle, with no register in the path.
- R7: If any bit of `cs_i` or `stb_i` is 1 during the blocked window, `fault_o` is 1 after the next rising edge. It stays 1 until reset.
- R8: If every strobe is idle through the blocked window, `fault_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request, asynchronous, active high |
| cs_i | input | NCS | Chip selects from the requester, active high |
| stb_i | input | NSTB | Address strobes from the requester, active high |
| cs_o | output | NCS | Chip selects passed to the array |
| stb_o | output | NSTB | Address strobes passed to the array |
| asleep_o | output | 1 | Sleep status |
| recovering_o | output | 1 | High during the post-wake recovery interval |
| fault_o | output | 1 | Sticky flag: an access arrived while blocked |

## Verification
The assertions assume that the sleep request never changes close to a rising edge. Under that assumption each synchroniser stage holds exactly the value it sampled, and the two-edge latency is exact rather than two or three edges. The bench changes the request and all strobes only on falling clock edges, which keeps the stimulus inside that assumption. The stimulus covers idle sleeps, sleeps with strobes active during entry, a full exit and recovery sequence, and a second reset that clears the sticky fault.

// File: rtl/sram_sleep_pkg.sv
// Shared defaults and types for the SRAM sleep controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_sleep_pkg;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_RECOV_CYC   = 8;

    // Phase view of the controller, used to form the blocking window.
    typedef struct packed {
        logic entering;
        logic asleep;
        logic recovering;
    } slp_view_t;
endpackage

// File: rtl/slp_sync.sv
// Multi-stage synchroniser for the asynchronous sleep request.
// Assumes: STAGES >= 2; all stages reset to 0 synchronously.
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_i,
    output logic [STAGES-1:0] stages_o
);
    logic [STAGES-1:0] sh;

    // Shift the request through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_i};
    end

    assign stages_o = sh;
endmodule

// File: rtl/slp_recov_timer.sv
// Down-counter for the post-wake recovery interval.
// Assumes: start_i pulses for one cycle at the edge where sleep ends; RECOV_CYC >= 1.
module slp_recov_timer #(
    parameter int RECOV_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(RECOV_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(RECOV_CYC);

    logic [CW-1:0] cnt;

    // Load on wake, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start_i)     cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/slp_access_guard.sv
// Blocks strobes to the array while blocked and records a sticky fault.
// Assumes: blk_i is registered-state derived and stable across a cycle.
module slp_access_guard #(
    parameter int NCS  = 3,
    parameter int NSTB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_i,
    input  logic [NCS-1:0]  cs_i,
    input  logic [NSTB-1:0] stb_i,
    output logic [NCS-1:0]  cs_o,
    output logic [NSTB-1:0] stb_o,
    output logic            fault_o
);
    logic hit;
    logic fault_q;

    // Gate strobes combinationally and detect a blocked access.
    always_comb begin
        cs_o  = blk_i ? '0 : cs_i;
        stb_o = blk_i ? '0 : stb_i;
        hit   = blk_i && ((|cs_i) || (|stb_i));
    end

    // Sticky fault, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   fault_q <= 1'b0;
        else if (hit) fault_q <= 1'b1;
    end

    assign fault_o = fault_q;

    // R7
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cs_i) || (|stb_i)) && blk_i |=> fault_o);
    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);
endmodule

// File: rtl/sram_sleep_ctrl.sv
// Top of the SRAM sleep controller: synchronises the sleep request,
// times recovery after wake and blocks strobes while asleep or recovering.
// Assumes: synchronous active-low reset; array power is handled elsewhere.
module sram_sleep_ctrl
    import sram_sleep_pkg::*;
#(
    parameter int NCS         = 3,
    parameter int NSTB        = 2,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int RECOV_CYC   = DEF_RECOV_CYC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req_i,
    input  logic [NCS-1:0]  cs_i,
    input  logic [NSTB-1:0] stb_i,
    output logic [NCS-1:0]  cs_o,
    output logic [NSTB-1:0] stb_o,
    output logic            asleep_o,
    output logic            recovering_o,
    output logic            fault_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] stg;
    logic                   wake_now;
    logic                   rec_busy;
    logic                   blk;
    slp_view_t              view;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_i      (sleep_req_i),
        .stages_o (stg)
    );

    // Sleep ends at the next edge when the last stage is high and the one before is low.
    assign wake_now = stg[LAST] && !stg[LAST-1];

    slp_recov_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wake_now),
        .busy_o  (rec_busy)
    );

    // Collect the phase view and form the blocking window.
    always_comb begin
        view.entering   = |stg[LAST-1:0];
        view.asleep     = stg[LAST];
        view.recovering = rec_busy;
        blk             = view.entering || view.asleep || view.recovering;
    end

    slp_access_guard #(.NCS(NCS), .NSTB(NSTB)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_i   (blk),
        .cs_i    (cs_i),
        .stb_i   (stb_i),
        .cs_o    (cs_o),
        .stb_o   (stb_o),
        .fault_o (fault_o)
    );

    assign asleep_o     = view.asleep;
    assign recovering_o = view.recovering;

    // R4
    wake_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep_o) |-> recovering_o);
    // R5
    blocked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o || recovering_o) |-> (cs_o == '0 && stb_o == '0));
    // R4
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(asleep_o && recovering_o && !$past(asleep_o)));
endmodule

// File: tb/sram_sleep_ctrl_test.sv
module sram_sleep_ctrl_test;
    localparam int NCS = 3;
    localparam int NSTB = 2;
    localparam int RECOV = 8;

    typedef struct {
        logic            asleep;
        logic            rec;
        logic            fault;
        logic [NCS-1:0]  cs;
        logic [NSTB-1:0] stb;
        string           tag;
    } item_t;

    logic clk = 0;
    logic rst_n = 0;
    logic req = 0;
    logic [NCS-1:0]  cs_i = '0;
    logic [NSTB-1:0] stb_i = '0;
    logic [NCS-1:0]  cs_o;
    logic [NSTB-1:0] stb_o;
    logic asleep_o, recovering_o, fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t q[$];

    // Behavioural model state, built from the requirements.
    logic m1 = 0, m2 = 0, mfault = 0;
    int   mrec = 0;

    always #2.5 clk = ~clk;

    sram_sleep_ctrl #(.NCS(NCS), .NSTB(NSTB), .RECOV_CYC(RECOV)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(req),
        .cs_i(cs_i), .stb_i(stb_i), .cs_o(cs_o), .stb_o(stb_o),
        .asleep_o(asleep_o), .recovering_o(recovering_o), .fault_o(fault_o)
    );

    // Driver: apply one cycle of stimulus and push what the outputs must be.
    task automatic step(input logic r, input logic [NCS-1:0] c,
                        input logic [NSTB-1:0] s, input string tag);
        item_t it;
        logic blk;
        @(negedge clk);
        req = r; cs_i = c; stb_i = s;
        blk = m1 || m2 || (mrec > 0);
        it.asleep = m2;
        it.rec    = (mrec > 0);
        it.fault  = mfault;
        it.cs     = blk ? '0 : c;
        it.stb    = blk ? '0 : s;
        it.tag    = tag;
        q.push_back(it);
        if (blk && ((|c) || (|s))) mfault = 1;
        if (m2 && !m1) mrec = RECOV;
        else if (mrec > 0) mrec--;
        m2 = m1;
        m1 = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; req = 0; cs_i = '0; stb_i = '0;
        repeat (3) @(negedge clk);
        m1 = 0; m2 = 0; mfault = 0; mrec = 0;
        rst_n = 1;
    endtask

    // Monitor: after inputs settle, pop the expected item and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                checks++;
                if (asleep_o !== e.asleep || recovering_o !== e.rec ||
                    fault_o !== e.fault || cs_o !== e.cs || stb_o !== e.stb) begin
                    errors++;
                    $display("FAIL %s: got asleep=%b rec=%b fault=%b cs=%b stb=%b exp asleep=%b rec=%b fault=%b cs=%b stb=%b",
                             e.tag, asleep_o, recovering_o, fault_o, cs_o, stb_o,
                             e.asleep, e.rec, e.fault, e.cs, e.stb);
                end
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state and pass-through
        step(0, 3'b000, 2'b00, "R1");
        // R6: strobes pass when awake
        step(0, 3'b101, 2'b01, "R6");
        step(0, 3'b010, 2'b10, "R6");
        // R2: entry latency, strobes idle (R8)
        step(1, 3'b000, 2'b00, "R2");
        step(1, 3'b000, 2'b00, "R2");
        step(1, 3'b000, 2'b00, "R2");
        for (int i = 0; i < 3; i++) step(1, 3'b000, 2'b00, "R8");
        // R3: exit latency
        step(0, 3'b000, 2'b00, "R3");
        step(0, 3'b000, 2'b00, "R3");
        step(0, 3'b000, 2'b00, "R3");
        // R4: recovery interval, idle so no fault (R8)
        for (int i = 0; i < RECOV + 1; i++) step(0, 3'b000, 2'b00, "R4");
        // R6: pass-through after recovery
        step(0, 3'b111, 2'b11, "R6");
        // R5/R7: strobe during entry window is blocked and faults
        step(1, 3'b000, 2'b00, "R5");
        step(1, 3'b001, 2'b00, "R5");
        step(1, 3'b000, 2'b10, "R7");
        step(0, 3'b000, 2'b00, "R7");
        step(0, 3'b000, 2'b00, "R7");
        // R5: strobe during recovery is blocked
        step(0, 3'b000, 2'b01, "R5");
        for (int i = 0; i < RECOV + 1; i++) step(0, 3'b000, 2'b00, "R7");
        step(0, 3'b100, 2'b00, "R7");
        // R1: reset clears the sticky fault
        do_reset();
        step(0, 3'b000, 2'b00, "R1");
        step(0, 3'b011, 2'b01, "R1");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule